// File: doc/BRIEF.md
# Descriptor-List Stream DMA Engine

This block serves a set of audio streams, each of which walks a list of buffer descriptors held in memory. A codec-side agent asks for a number of bytes on a stream number and direction. The engine picks the matching stream slot and cuts the request into chunks that never cross the end of a descriptor or the end of the stream's cyclic buffer. It issues each chunk to memory as a data-move command and advances the stream's link position, which wraps around the cyclic buffer.

Descriptors are fetched from memory when they are needed, one 16-byte entry at a time. An entry can ask for an interrupt when it is used up. The engine then raises the stream's buffer-completion status bit and moves no more data on that stream until software clears the bit. A global position-buffer base can be enabled. When it is, the engine writes the updated link position of a stream into that stream's 8-byte slot in memory after every chunk.

Software reaches the per-stream registers through a simple slot/field write and read port. Streams are started by a rising edge of the run bit and stopped by its falling edge. A stream reset bit returns a stream to its idle state.

Top module: `stream_bdl_dma`

## Requirements
- R1: The lower half of the slots (0 to NUM_STREAMS/2-1) are input streams and the upper half are output streams. A request considers only the slots of its direction. It is served by the lowest-numbered of those slots whose control bits 23:20 equal the requested stream number.
- R2: Each chunk is the smallest of three values: the bytes still requested, the cyclic length minus the link position, and the bytes left in the current descriptor.
- R3: A descriptor is read at list base + 16*index as four words: address low, address high, length, flags. Flags bit 0 asks for an interrupt. When a descriptor is used up the index advances, and after index LVI it wraps to 0.
- R4: The link position increases by each chunk and becomes 0 when it reaches the cyclic length.
- R5: Using up a descriptor whose interrupt flag is set sets control bit 26. The request ends there, and the stream moves no data until that bit is cleared.
- R6: A request with no matching slot, or on a stopped or stalled stream, completes with 0 bytes and changes no link position.
- R7: When bit 0 of the position-buffer base is set, each chunk is followed by a memory op with code 1 (word write). It goes to (base with bit 0 cleared) + 8*slot and carries the new link position. With bit 0 clear, no such op is issued.
- R8: Writing control bit 0 as 1 resets the stream. The control word then reads 0x2000_0000, and the link position and descriptor walk go to zero. The control word of every slot also reads 0x2000_0000 after the block reset.
- R9: A 0-to-1 write of control bit 1 (run) restarts the walk at descriptor 0, offset 0. A 1-to-0 write stops the stream.
- R10: Register select codes are 0 control, 1 cyclic length, 2 LVI, 3 list base low, 4 list base high, 5 link position (read only), 6 position-buffer base low, 7 position-buffer base high. Codes 6 and 7 are shared by all slots. Bits 6:0 of the list base low always read 0.
- R11: Control bits 28:26 are cleared by writing 1 to them and are kept when 0 is written.
- R12: A chunk is issued as memory op code 2 with its address (descriptor address + offset) and length. The write-enable is high for input streams and low for output streams. Descriptor reads use op code 0.
- R13: Each request ends with a single-cycle done pulse that carries the total number of bytes moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_slot_i | input | SLOT_W | Stream slot for register access |
| reg_field_i | input | 3 | Register select code |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| xfer_req_i | input | 1 | Transfer request pulse |
| xfer_out_i | input | 1 | Direction: 1 output, 0 input |
| xfer_stnr_i | input | 4 | Requested stream number |
| xfer_len_i | input | XLEN_W | Requested bytes |
| xfer_done_o | output | 1 | Request finished |
| xfer_bytes_o | output | XLEN_W | Bytes moved for the finished request |
| mem_req_o | output | 1 | Memory op valid |
| mem_op_o | output | 2 | 0 descriptor read, 1 position write, 2 data move |
| mem_we_o | output | 1 | Op writes memory |
| mem_addr_o | output | 64 | Byte address |
| mem_len_o | output | 32 | Byte count of the op |
| mem_wdata_o | output | 32 | Write data for position writes |
| mem_ack_i | input | 1 | Memory op accepted |
| mem_rdata_i | input | 32 | Read data, valid with the ack |

## Verification
The bench builds the block with eight slots and 16-bit request lengths. That gives four input and four output slots, enough to put the same stream number on both directions and show that direction keeps them apart. A three-entry descriptor list with one interrupt entry and a cyclic length of 100 bytes makes single requests cross descriptor ends, wrap the link position and wrap the list inside one run. A one-entry list on an input slot checks the wrap after index 0.

// File: rtl/sdl_dma_pkg.sv
`timescale 1ns/1ps
package sdl_dma_pkg;
  localparam int ADDR_W = 64;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 8;

  localparam int CTL_RST  = 0;
  localparam int CTL_RUN  = 1;
  localparam int CTL_BCIS = 26;
  localparam logic [WORD_W-1:0] CTL_IDLE = 32'h2000_0000;

  typedef enum logic [2:0] {
    FLD_CTL, FLD_CBL, FLD_LVI, FLD_BDL_LO, FLD_BDL_HI, FLD_LPIB, FLD_POS_LO, FLD_POS_HI
  } field_e;

  typedef enum logic [1:0] {
    OP_DESC_RD = 2'd0, OP_POS_WR = 2'd1, OP_DATA = 2'd2
  } mem_op_e;

  typedef struct packed {
    logic [WORD_W-1:0] lpib;
    logic [IDX_W-1:0]  be;
    logic [WORD_W-1:0] bp;
    logic [ADDR_W-1:0] daddr;
    logic [WORD_W-1:0] dlen;
    logic              dioc;
    logic              dvalid;
    logic              set_bcis;
  } walk_upd_t;

  typedef struct packed {
    logic [WORD_W-1:0] ctl;
    logic [WORD_W-1:0] cbl;
    logic [IDX_W-1:0]  lvi;
    logic [ADDR_W-1:0] bdl;
    logic [WORD_W-1:0] lpib;
    logic [IDX_W-1:0]  be;
    logic [WORD_W-1:0] bp;
    logic [ADDR_W-1:0] daddr;
    logic [WORD_W-1:0] dlen;
    logic              dioc;
    logic              dvalid;
  } stream_t;
endpackage

// File: rtl/sdl_stream_regs.sv
`timescale 1ns/1ps
module sdl_stream_regs
  import sdl_dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_we_i,
  input  field_e            sw_field_i,
  input  logic [WORD_W-1:0] sw_wdata_i,
  input  logic              upd_we_i,
  input  walk_upd_t         upd_i,
  output stream_t           st_o
);
  stream_t st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= '0;
      st_q.ctl <= CTL_IDLE;
    end else begin
      if (sw_we_i) begin
        unique case (sw_field_i)
          FLD_CTL: begin
            if (sw_wdata_i[CTL_RST]) begin
              st_q     <= '0;
              st_q.cbl <= st_q.cbl;
              st_q.lvi <= st_q.lvi;
              st_q.bdl <= st_q.bdl;
              st_q.ctl <= CTL_IDLE;
            end else begin
              st_q.ctl[CTL_RUN] <= sw_wdata_i[CTL_RUN];
              st_q.ctl[23:20]   <= sw_wdata_i[23:20];
              st_q.ctl[28:26]   <= st_q.ctl[28:26] & ~sw_wdata_i[28:26];
              // run rising edge restarts the walk
              if (sw_wdata_i[CTL_RUN] && !st_q.ctl[CTL_RUN]) begin
                st_q.be     <= '0;
                st_q.bp     <= '0;
                st_q.dvalid <= 1'b0;
              end
            end
          end
          FLD_CBL:    st_q.cbl <= sw_wdata_i;
          FLD_LVI:    st_q.lvi <= sw_wdata_i[IDX_W-1:0];
          FLD_BDL_LO: st_q.bdl[WORD_W-1:0] <= {sw_wdata_i[WORD_W-1:7], 7'b0};
          FLD_BDL_HI: st_q.bdl[ADDR_W-1:WORD_W] <= sw_wdata_i;
          default: ;
        endcase
      end
      if (upd_we_i) begin
        st_q.lpib   <= upd_i.lpib;
        st_q.be     <= upd_i.be;
        st_q.bp     <= upd_i.bp;
        st_q.daddr  <= upd_i.daddr;
        st_q.dlen   <= upd_i.dlen;
        st_q.dioc   <= upd_i.dioc;
        st_q.dvalid <= upd_i.dvalid;
        if (upd_i.set_bcis) st_q.ctl[CTL_BCIS] <= 1'b1;
      end
    end
  end

  assign st_o = st_q;

  AST_LPIB_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(upd_we_i) && $stable(st_q.cbl) && st_q.cbl != '0) |-> (st_q.lpib < st_q.cbl)); // R4
endmodule

// File: rtl/sdl_chunk_calc.sv
`timescale 1ns/1ps
module sdl_chunk_calc #(
  parameter int W = 32
) (
  input  logic [W-1:0] left_i,
  input  logic [W-1:0] cbl_i,
  input  logic [W-1:0] lpib_i,
  input  logic [W-1:0] dlen_i,
  input  logic [W-1:0] bp_i,
  output logic [W-1:0] chunk_o,
  output logic [W-1:0] lpib_next_o,
  output logic [W-1:0] bp_next_o,
  output logic         desc_done_o
);
  logic [W-1:0] room_cyc, room_desc, m1, lpib_sum;

  always_comb begin
    room_cyc    = (lpib_i < cbl_i) ? cbl_i - lpib_i : '0;
    room_desc   = (bp_i < dlen_i) ? dlen_i - bp_i : '0;
    m1          = (left_i < room_cyc) ? left_i : room_cyc;
    chunk_o     = (m1 < room_desc) ? m1 : room_desc;
    lpib_sum    = lpib_i + chunk_o;
    lpib_next_o = (lpib_sum >= cbl_i) ? '0 : lpib_sum;
    bp_next_o   = bp_i + chunk_o;
    desc_done_o = (bp_next_o >= dlen_i);
  end
endmodule

// File: rtl/sdl_dma_engine.sv
`timescale 1ns/1ps
module sdl_dma_engine
  import sdl_dma_pkg::*;
#(
  parameter int NUM_STREAMS = 8,
  parameter int XLEN_W      = 16,
  localparam int SLOT_W     = $clog2(NUM_STREAMS),
  localparam int HALF       = NUM_STREAMS / 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  stream_t [NUM_STREAMS-1:0]   st_i,
  input  logic [ADDR_W-1:0]           pos_base_i,
  input  logic                        xfer_req_i,
  input  logic                        xfer_out_i,
  input  logic [3:0]                  xfer_stnr_i,
  input  logic [XLEN_W-1:0]           xfer_len_i,
  output logic                        xfer_done_o,
  output logic [XLEN_W-1:0]           xfer_bytes_o,
  output logic [NUM_STREAMS-1:0]      upd_we_o,
  output walk_upd_t                   upd_o,
  output logic                        mem_req_o,
  output logic [1:0]                  mem_op_o,
  output logic                        mem_we_o,
  output logic [ADDR_W-1:0]           mem_addr_o,
  output logic [WORD_W-1:0]           mem_len_o,
  output logic [WORD_W-1:0]           mem_wdata_o,
  input  logic                        mem_ack_i,
  input  logic [WORD_W-1:0]           mem_rdata_i
);
  typedef enum logic [2:0] {E_IDLE, E_CHECK, E_FETCH, E_MOVE, E_POS, E_DONE} eng_e;

  eng_e               state_q;
  logic [SLOT_W-1:0]  slot_q, hit_slot;
  logic               hit_found, out_q;
  logic [XLEN_W-1:0]  left_q, total_q;
  logic [1:0]         k_q;
  logic [WORD_W-1:0]  tmp_alo_q, tmp_ahi_q, tmp_len_q;
  stream_t            cur;
  logic [WORD_W-1:0]  chunk, lpib_next, bp_next;
  logic               desc_done;
  logic [IDX_W-1:0]   be_next;

  // lowest matching slot of the requested direction wins
  always_comb begin
    hit_found = 1'b0;
    hit_slot  = '0;
    for (int i = HALF - 1; i >= 0; i--) begin
      if (st_i[(xfer_out_i ? HALF : 0) + i].ctl[23:20] == xfer_stnr_i) begin
        hit_found = 1'b1;
        hit_slot  = SLOT_W'((xfer_out_i ? HALF : 0) + i);
      end
    end
  end

  assign cur = st_i[slot_q];

  sdl_chunk_calc #(.W(WORD_W)) u_calc (
    .left_i(WORD_W'(left_q)), .cbl_i(cur.cbl), .lpib_i(cur.lpib),
    .dlen_i(cur.dlen), .bp_i(cur.bp), .chunk_o(chunk),
    .lpib_next_o(lpib_next), .bp_next_o(bp_next), .desc_done_o(desc_done)
  );

  assign be_next = (cur.be == cur.lvi) ? '0 : cur.be + 1'b1;

  always_comb begin
    upd_o.lpib     = cur.lpib;
    upd_o.be       = cur.be;
    upd_o.bp       = cur.bp;
    upd_o.daddr    = cur.daddr;
    upd_o.dlen     = cur.dlen;
    upd_o.dioc     = cur.dioc;
    upd_o.dvalid   = cur.dvalid;
    upd_o.set_bcis = 1'b0;
    upd_we_o       = '0;
    if (state_q == E_FETCH && mem_ack_i && k_q == 2'd3) begin
      upd_o.daddr  = {tmp_ahi_q, tmp_alo_q};
      upd_o.dlen   = tmp_len_q;
      upd_o.dioc   = mem_rdata_i[0];
      upd_o.dvalid = 1'b1;
      upd_we_o[slot_q] = 1'b1;
    end else if (state_q == E_MOVE && mem_ack_i) begin
      upd_o.lpib     = lpib_next;
      upd_o.bp       = desc_done ? '0 : bp_next;
      upd_o.be       = desc_done ? be_next : cur.be;
      upd_o.dvalid   = !desc_done;
      upd_o.set_bcis = desc_done && cur.dioc;
      upd_we_o[slot_q] = 1'b1;
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_op_o    = OP_DESC_RD;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_len_o   = WORD_W'(4);
    mem_wdata_o = cur.lpib;
    unique case (state_q)
      E_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur.bdl + ADDR_W'({cur.be, 4'b0}) + ADDR_W'({k_q, 2'b0});
      end
      E_MOVE: begin
        mem_req_o  = 1'b1;
        mem_op_o   = OP_DATA;
        mem_we_o   = !out_q;
        mem_addr_o = cur.daddr + ADDR_W'(cur.bp);
        mem_len_o  = chunk;
      end
      E_POS: begin
        mem_req_o  = 1'b1;
        mem_op_o   = OP_POS_WR;
        mem_we_o   = 1'b1;
        mem_addr_o = {pos_base_i[ADDR_W-1:1], 1'b0} + ADDR_W'({slot_q, 3'b0});
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= E_IDLE;
      slot_q    <= '0;
      out_q     <= 1'b0;
      left_q    <= '0;
      total_q   <= '0;
      k_q       <= '0;
      tmp_alo_q <= '0;
      tmp_ahi_q <= '0;
      tmp_len_q <= '0;
    end else begin
      unique case (state_q)
        E_IDLE: if (xfer_req_i) begin
          out_q   <= xfer_out_i;
          left_q  <= xfer_len_i;
          total_q <= '0;
          slot_q  <= hit_slot;
          state_q <= (hit_found && st_i[hit_slot].ctl[CTL_RUN] && !st_i[hit_slot].ctl[CTL_BCIS])
                     ? E_CHECK : E_DONE;
        end
        E_CHECK: begin
          k_q <= '0;
          if (left_q == '0 || cur.ctl[CTL_BCIS] || !cur.ctl[CTL_RUN]) state_q <= E_DONE;
          else if (!cur.dvalid)                                         state_q <= E_FETCH;
          else if (chunk == '0)                                         state_q <= E_DONE;
          else                                                          state_q <= E_MOVE;
        end
        E_FETCH: if (mem_ack_i) begin
          k_q <= k_q + 1'b1;
          unique case (k_q)
            2'd0: tmp_alo_q <= mem_rdata_i;
            2'd1: tmp_ahi_q <= mem_rdata_i;
            2'd2: tmp_len_q <= mem_rdata_i;
            default: state_q <= E_CHECK;
          endcase
        end
        E_MOVE: if (mem_ack_i) begin
          left_q  <= left_q - chunk[XLEN_W-1:0];
          total_q <= total_q + chunk[XLEN_W-1:0];
          state_q <= pos_base_i[0] ? E_POS : E_CHECK;
        end
        E_POS:  if (mem_ack_i) state_q <= E_CHECK;
        E_DONE: state_q <= E_IDLE;
        default: state_q <= E_IDLE;
      endcase
    end
  end

  assign xfer_done_o  = (state_q == E_DONE);
  assign xfer_bytes_o = total_q;

  AST_CHUNK_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == E_MOVE) |-> (mem_len_o != '0 && mem_len_o <= WORD_W'(left_q))); // R2
  AST_NO_MOVE_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == E_MOVE) |-> (!cur.ctl[CTL_BCIS] && cur.ctl[CTL_RUN])); // R5
  AST_FETCH_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == E_FETCH) |-> (mem_addr_o[1:0] == 2'b00)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |=> !xfer_done_o); // R13
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == E_IDLE) |-> (upd_we_o == '0 && !mem_req_o)); // R6
endmodule

// File: rtl/stream_bdl_dma.sv
`timescale 1ns/1ps
module stream_bdl_dma
  import sdl_dma_pkg::*;
#(
  parameter int NUM_STREAMS = 8,
  parameter int XLEN_W      = 16,
  localparam int SLOT_W     = $clog2(NUM_STREAMS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [SLOT_W-1:0] reg_slot_i,
  input  logic [2:0]        reg_field_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              xfer_req_i,
  input  logic              xfer_out_i,
  input  logic [3:0]        xfer_stnr_i,
  input  logic [XLEN_W-1:0] xfer_len_i,
  output logic              xfer_done_o,
  output logic [XLEN_W-1:0] xfer_bytes_o,
  output logic              mem_req_o,
  output logic [1:0]        mem_op_o,
  output logic              mem_we_o,
  output logic [63:0]       mem_addr_o,
  output logic [31:0]       mem_len_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i
);
  stream_t [NUM_STREAMS-1:0] st;
  logic [NUM_STREAMS-1:0]    upd_we;
  walk_upd_t                 upd;
  logic [ADDR_W-1:0]         pos_base_q;
  field_e                    fld;
  stream_t                   sel;

  assign fld = field_e'(reg_field_i);

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_stream
    sdl_stream_regs u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .sw_we_i(reg_we_i && reg_slot_i == SLOT_W'(g)),
      .sw_field_i(fld), .sw_wdata_i(reg_wdata_i),
      .upd_we_i(upd_we[g]), .upd_i(upd), .st_o(st[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_base_q <= '0;
    else if (reg_we_i && fld == FLD_POS_LO) pos_base_q[WORD_W-1:0] <= reg_wdata_i;
    else if (reg_we_i && fld == FLD_POS_HI) pos_base_q[ADDR_W-1:WORD_W] <= reg_wdata_i;
  end

  assign sel = st[reg_slot_i];

  always_comb begin
    unique case (fld)
      FLD_CTL:    reg_rdata_o = sel.ctl;
      FLD_CBL:    reg_rdata_o = sel.cbl;
      FLD_LVI:    reg_rdata_o = WORD_W'(sel.lvi);
      FLD_BDL_LO: reg_rdata_o = sel.bdl[WORD_W-1:0];
      FLD_BDL_HI: reg_rdata_o = sel.bdl[ADDR_W-1:WORD_W];
      FLD_LPIB:   reg_rdata_o = sel.lpib;
      FLD_POS_LO: reg_rdata_o = pos_base_q[WORD_W-1:0];
      default:    reg_rdata_o = pos_base_q[ADDR_W-1:WORD_W];
    endcase
  end

  sdl_dma_engine #(.NUM_STREAMS(NUM_STREAMS), .XLEN_W(XLEN_W)) u_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .st_i(st), .pos_base_i(pos_base_q),
    .xfer_req_i(xfer_req_i), .xfer_out_i(xfer_out_i), .xfer_stnr_i(xfer_stnr_i),
    .xfer_len_i(xfer_len_i), .xfer_done_o(xfer_done_o), .xfer_bytes_o(xfer_bytes_o),
    .upd_we_o(upd_we), .upd_o(upd),
    .mem_req_o(mem_req_o), .mem_op_o(mem_op_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_len_o(mem_len_o), .mem_wdata_o(mem_wdata_o),
    .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i)
  );
endmodule

// File: tb/stream_bdl_dma_test.sv
`timescale 1ns/1ps
module stream_bdl_dma_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_slot = '0, reg_field = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic xfer_req = 1'b0, xfer_out = 1'b0;
  logic [3:0] xfer_stnr = '0;
  logic [15:0] xfer_len = '0, xfer_bytes;
  logic xfer_done, mem_req, mem_we, mem_ack;
  logic [1:0] mem_op;
  logic [63:0] mem_addr;
  logic [31:0] mem_len, mem_wdata, mem_rdata;
  int checks = 0, errors = 0;
  int pos_count = 0;
  logic [63:0] last_daddr, last_paddr;
  logic [31:0] last_dlen, last_pdata;
  logic last_dwe;

  always #10 clk = ~clk;

  stream_bdl_dma uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_slot_i(reg_slot),
    .reg_field_i(reg_field), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .xfer_req_i(xfer_req), .xfer_out_i(xfer_out), .xfer_stnr_i(xfer_stnr),
    .xfer_len_i(xfer_len), .xfer_done_o(xfer_done), .xfer_bytes_o(xfer_bytes),
    .mem_req_o(mem_req), .mem_op_o(mem_op), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_len_o(mem_len), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  // memory model: zero-wait, list at 0x80 with three entries
  assign mem_ack = mem_req;
  always_comb begin
    case (mem_addr)
      64'h80:  mem_rdata = 32'h1000;
      64'h88:  mem_rdata = 32'd40;
      64'h90:  mem_rdata = 32'h2000;
      64'h98:  mem_rdata = 32'd30;
      64'h9c:  mem_rdata = 32'd1;
      64'ha0:  mem_rdata = 32'h3000;
      64'ha8:  mem_rdata = 32'd50;
      default: mem_rdata = 32'd0;
    endcase
  end

  always @(posedge clk) if (mem_req && mem_ack) begin
    if (mem_op == 2'd2) begin
      last_daddr <= mem_addr; last_dlen <= mem_len; last_dwe <= mem_we;
    end
    if (mem_op == 2'd1) begin
      last_paddr <= mem_addr; last_pdata <= mem_wdata; pos_count <= pos_count + 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int slot, input int fld, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_slot = 3'(slot); reg_field = 3'(fld); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int slot, input int fld, output logic [31:0] d);
    @(negedge clk);
    reg_slot = 3'(slot); reg_field = 3'(fld);
    #1 d = reg_rdata;
  endtask

  task automatic xfer(input logic out, input logic [3:0] stnr, input logic [15:0] len,
                      output logic [15:0] bytes);
    int n;
    @(negedge clk);
    xfer_req = 1'b1; xfer_out = out; xfer_stnr = stnr; xfer_len = len;
    @(negedge clk);
    xfer_req = 1'b0;
    n = 0;
    while (!xfer_done && n < 500) begin @(negedge clk); n++; end
    bytes = xfer_done ? xfer_bytes : 16'hdead;
    chk("R13 done pulse seen", 64'(xfer_done), 64'd1);
  endtask

  typedef struct packed {
    logic        ack;
    logic        out;
    logic [3:0]  stnr;
    logic [15:0] len;
    logic [15:0] exp_bytes;
    logic [31:0] exp_lpib;
  } vec_t;

  // output slot 4, stnr 5, cbl 100, list d0 40B / d1 30B irq / d2 50B
  localparam vec_t VECS [7] = '{
    '{1'b0, 1'b1, 4'd5, 16'd16, 16'd16, 32'd16},  // R2 bound by request
    '{1'b0, 1'b1, 4'd5, 16'd30, 16'd30, 32'd46},  // R3 crosses d0 end
    '{1'b0, 1'b1, 4'd5, 16'd40, 16'd24, 32'd70},  // R5 stops at irq entry
    '{1'b0, 1'b1, 4'd5, 16'd10, 16'd0,  32'd70},  // R6 stalled
    '{1'b1, 1'b1, 4'd5, 16'd40, 16'd40, 32'd10},  // R4 wraps at cbl
    '{1'b0, 1'b1, 4'd5, 16'd25, 16'd25, 32'd35},  // R3 list wrap after LVI
    '{1'b0, 1'b1, 4'd9, 16'd8,  16'd0,  32'd35}   // R6 no matching slot
  };

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL R13 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [15:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(0, 0, d); chk("R8 reset ctl slot0", 64'(d), 64'h2000_0000);
    rd(7, 0, d); chk("R8 reset ctl slot7", 64'(d), 64'h2000_0000);
    rd(0, 5, d); chk("R8 reset lpib", 64'(d), 64'd0);

    wr(2, 3, 32'hFFFF_FFFF); rd(2, 3, d); chk("R10 list base low bits 6:0", 64'(d), 64'hFFFF_FF80);

    wr(4, 1, 100); wr(4, 2, 2); wr(4, 3, 32'h80); wr(4, 4, 0);
    wr(4, 0, 32'h0050_0002);

    foreach (VECS[i]) begin
      if (VECS[i].ack) begin
        wr(4, 0, 32'h0050_0002); rd(4, 0, d);
        chk("R11 write 0 keeps bit 26", 64'(d[26]), 64'd1);
        wr(4, 0, 32'h0450_0002); rd(4, 0, d);
        chk("R11 W1C clears bit 26", 64'(d[26]), 64'd0);
      end
      xfer(VECS[i].out, VECS[i].stnr, VECS[i].len, b);
      chk($sformatf("R2 vec%0d bytes", i), 64'(b), 64'(VECS[i].exp_bytes));
      rd(4, 5, d);
      chk($sformatf("R4 vec%0d lpib", i), 64'(d), 64'(VECS[i].exp_lpib));
      if (i == 2) begin
        rd(4, 0, d); chk("R5 bit 26 set at irq entry", 64'(d[26]), 64'd1);
      end
    end
    chk("R12 output data op reads memory", 64'(last_dwe), 64'd0);
    chk("R7 no position write when disabled", 64'(pos_count), 64'd0);

    // input slot 1 with the same stream number, one-entry list
    wr(1, 1, 64); wr(1, 2, 0); wr(1, 3, 32'h80); wr(1, 0, 32'h0050_0002);
    xfer(1'b0, 4'd5, 16'd50, b);
    chk("R1 input slot bytes", 64'(b), 64'd50);
    rd(1, 5, d); chk("R1 input slot lpib", 64'(d), 64'd50);
    rd(4, 5, d); chk("R1 output slot untouched", 64'(d), 64'd35);
    chk("R12 input data op writes memory", 64'(last_dwe), 64'd1);
    chk("R3 wrap after index 0 addr", last_daddr, 64'h1000);
    chk("R3 wrap after index 0 len", 64'(last_dlen), 64'd10);

    wr(0, 6, 32'h401);
    xfer(1'b1, 4'd5, 16'd5, b);
    chk("R7 bytes", 64'(b), 64'd5);
    chk("R7 position addr", last_paddr, 64'h420);
    chk("R7 position data", 64'(last_pdata), 64'd40);
    chk("R12 data addr at offset", last_daddr, 64'h100f);

    wr(1, 0, 32'h0050_0000);
    xfer(1'b0, 4'd5, 16'd8, b);
    chk("R9 stopped stream moves nothing", 64'(b), 64'd0);
    rd(1, 5, d); chk("R6 stopped lpib kept", 64'(d), 64'd50);
    wr(1, 0, 32'h0050_0002);
    xfer(1'b0, 4'd5, 16'd4, b);
    chk("R9 restart bytes", 64'(b), 64'd4);
    chk("R9 restart at descriptor 0 offset 0", last_daddr, 64'h1000);

    wr(4, 0, 32'h0000_0001);
    rd(4, 0, d); chk("R8 stream reset ctl", 64'(d), 64'h2000_0000);
    rd(4, 5, d); chk("R8 stream reset lpib", 64'(d), 64'd0);
    xfer(1'b1, 4'd5, 16'd4, b);
    chk("R6 after stream reset", 64'(b), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule